// File: doc/BRIEF.md
# DVMA I/O Address Translation Unit

This block sits between an I/O bus master and main memory and turns the device's virtual addresses into physical ones. The translated range is a window that always ends at the top of the 32-bit space. Its size is picked by a 3-bit code, from 16 MB up to 2 GB. A virtual page inside the window is looked up in a one-level page table held in memory. Results are kept in a small direct-mapped translation buffer, so that repeated accesses to a page need no memory read.

Software sets up the unit through a simple write port. That port holds a control word with an enable bit and the window-size code, the page-table base address, and one configuration word per device slot. Two further write-only locations act as commands: one discards every cached translation, and the other discards the translation of one page. A slot whose configuration sets bypass skips translation entirely. Its address goes straight out, with physical bit 30 taken from the configuration word.

Requests are taken one at a time over a valid/ready handshake. A lookup that fails ends in a one-cycle fault pulse that carries the offending address, and no response is given. A good lookup returns the physical address through a second valid/ready handshake. Page-table entries are read through a request/response memory port.

Top module: `dvx_xlate`

## Requirements
- R1: After reset the translation buffer is empty, `req_ready` is 1, and `rsp_valid`, `fault_valid` and `mem_req_valid` are 0.
- R2: A write with `cfg_we` stores `cfg_wdata` according to `cfg_sel`: 0 is control (bit 0 enable, bits 4:2 window code), 1 is the page-table base, 2 is flush-all, 3 is page flush, and 4+s is the configuration word of slot s.
- R3: With the enable bit clear, a non-bypass request returns `rsp_paddr` equal to the virtual address, and no memory read is made.
- R4: With the unit enabled, the window starts at 2^32 − 2^(24+code). A non-bypass address below the window raises `fault_valid` for one cycle with `fault_vaddr` equal to that address, and no memory read is made.
- R5: On a buffer miss, one entry is read at `mem_req_addr` = base + 4·((vaddr − window start) >> 12).
- R6: From an entry, the physical address is {0, entry[26:8], vaddr[11:0]}. Entry bit 1 means valid and entry bit 2 means writable.
- R7: An entry with bit 1 clear, or a write to a page whose bit 2 is clear, raises a fault. This holds for a freshly read entry and for a cached one. A faulting entry is never cached.
- R8: The buffer holds 16 entries. It is indexed by vaddr[15:12] and tagged by vaddr[31:12]. A hit makes no memory read, and a page with the same index evicts the one already held there.
- R9: Any write to flush-all, whatever its value, invalidates every cached translation.
- R10: A page flush invalidates only an entry whose tag equals `cfg_wdata[31:12]`. The low 12 bits of the written value are ignored, and another page that shares the index is kept.
- R11: A slot whose configuration bit 0 is set gets `rsp_paddr` equal to vaddr, with bit 30 replaced by configuration bit 16. This happens whatever the enable bit and the window say, and no memory read is made.
- R12: Only one request is in flight. `req_ready` stays 0 from acceptance until the response has been taken. `rsp_valid` and `rsp_paddr` stay stable until `rsp_ready`. A fault is a single-cycle pulse with no response.
- R13: If a flush is written while a page-table read is in flight, the fetched entry is still used for that response but is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (3) | Configuration location select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_slot | input | SLOT_W (2) | Requesting device slot |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Physical address valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | One-cycle translation fault pulse |
| fault_vaddr | output | 32 | Address that faulted |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry |

## Verification
The bench goes after the window edge for the smallest and largest codes. Getting the edge wrong either translates an address it should fault on, or faults one address inside the window. It targets faulting entries being refetched rather than cached; a design that cached them would give a second access no memory read. It issues page flushes aimed at a page that shares an index with a cached page but carries a different tag, and a design that skips the tag compare would lose the cached page. It also writes a flush while an entry read is in flight, which catches a design that keeps the stale entry, and it holds `rsp_ready` low to check that the response and `req_ready` hold steady.

// File: rtl/dvx_pkg.sv
package dvx_pkg;
  localparam int AW        = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = AW - PAGE_BITS;
  localparam int PPN_W     = 19;
  localparam int PTE_PPN_LSB  = 8;
  localparam int PTE_VALID    = 1;
  localparam int PTE_WRITE    = 2;
  localparam int SIZE_W       = 3;
  localparam int MIN_WIN_LOG2 = 24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_WAIT, ST_RESP, ST_FAULT
  } xl_state_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             writable;
  } tlb_data_t;

  // lowest address covered by the window for a size code
  function automatic logic [AW-1:0] window_base(input logic [SIZE_W-1:0] code);
    logic [AW-1:0] span_m1;
    span_m1 = (AW'(1) << (MIN_WIN_LOG2 + int'(code))) - AW'(1);
    return ~span_m1;
  endfunction

  // memory address of the table entry for a virtual address
  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] tbase,
                                               input logic [AW-1:0] va,
                                               input logic [AW-1:0] wbase);
    logic [AW-1:0] idx;
    idx = (va - wbase) >> PAGE_BITS;
    return tbase + (idx << 2);
  endfunction

  function automatic logic [AW-1:0] phys_addr(input logic [PPN_W-1:0] ppn,
                                              input logic [AW-1:0] va);
    return {1'b0, ppn, va[PAGE_BITS-1:0]};
  endfunction

  function automatic logic [AW-1:0] bypass_addr(input logic [AW-1:0] va,
                                                input logic a30);
    return {va[31], a30, va[29:0]};
  endfunction
endpackage

// File: rtl/dvx_regs.sv
module dvx_regs import dvx_pkg::*; #(
  parameter int NUM_SLOTS = 4,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     sel,
  input  logic [AW-1:0]        wdata,
  output logic                 xl_enable,
  output logic [SIZE_W-1:0]    size_code,
  output logic [AW-1:0]        pt_base,
  output logic                 flush_all,
  output logic                 flush_page,
  output logic [VPN_W-1:0]     flush_vpn,
  output logic [NUM_SLOTS-1:0] slot_bypass,
  output logic [NUM_SLOTS-1:0] slot_a30
);
  localparam logic [SEL_W-1:0] SEL_CTRL  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_FALL  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_FPAGE = SEL_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_enable <= 1'b0;
      size_code <= '0;
      pt_base   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        xl_enable <= wdata[0];
        size_code <= wdata[4:2];
      end
      if (sel == SEL_BASE) pt_base <= wdata;
    end
  end

  // command locations: the write itself is the event
  assign flush_all  = wr_en && (sel == SEL_FALL);
  assign flush_page = wr_en && (sel == SEL_FPAGE);
  assign flush_vpn  = wdata[AW-1:PAGE_BITS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_bypass[s] <= 1'b0;
        slot_a30[s]    <= 1'b0;
      end else if (wr_en && sel == SEL_W'(4 + s)) begin
        slot_bypass[s] <= wdata[0];
        slot_a30[s]    <= wdata[16];
      end
    end
  end
endmodule

// File: rtl/dvx_tlb.sv
module dvx_tlb import dvx_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output tlb_data_t        lk_data,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  tlb_data_t        fill_data,
  input  logic             inv_all,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  tlb_data_t          data_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign inv_idx  = inv_vpn[IDX_W-1:0];

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_vpn);
  assign lk_data = data_q[lk_idx];

  // a page flush only removes the entry whose tag matches
  logic page_kill;
  assign page_kill = inv_page && valid_q[inv_idx] && (tag_q[inv_idx] == inv_vpn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (page_kill && inv_idx == IDX_W'(e)) valid_q[e] <= 1'b0;
        else if (fill_en && fill_idx == IDX_W'(e)) valid_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_vpn;
      data_q[fill_idx] <= fill_data;
    end
  end

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

  a_r10_page_flush_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_page && !inv_all && !fill_en) |=>
      ($countones(valid_q) + 1 >= $countones($past(valid_q))));
endmodule

// File: rtl/dvx_xlate.sv
module dvx_xlate import dvx_pkg::*; #(
  parameter int NUM_SLOTS   = 4,
  parameter int TLB_ENTRIES = 16,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SEL_W  = $clog2(4 + NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_paddr,
  output logic              fault_valid,
  output logic [31:0]       fault_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  // configuration state
  logic                 xl_enable, flush_all, flush_page;
  logic [SIZE_W-1:0]    size_code;
  logic [AW-1:0]        pt_base;
  logic [VPN_W-1:0]     flush_vpn;
  logic [NUM_SLOTS-1:0] slot_bypass, slot_a30;

  dvx_regs #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .xl_enable(xl_enable), .size_code(size_code), .pt_base(pt_base),
    .flush_all(flush_all), .flush_page(flush_page), .flush_vpn(flush_vpn),
    .slot_bypass(slot_bypass), .slot_a30(slot_a30)
  );

  // request state
  xl_state_e         state_q, state_d;
  logic [AW-1:0]     va_q, paddr_q, paddr_d, maddr_q, maddr_d;
  logic              wr_q, stale_q;
  logic [SLOT_W-1:0] slot_q;

  // translation buffer
  logic      tlb_hit, tlb_fill;
  tlb_data_t tlb_rd, tlb_wr;
  assign tlb_wr.ppn      = mem_rsp_data[PTE_PPN_LSB +: PPN_W];
  assign tlb_wr.writable = mem_rsp_data[PTE_WRITE];

  dvx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(va_q[AW-1:PAGE_BITS]), .lk_hit(tlb_hit), .lk_data(tlb_rd),
    .fill_en(tlb_fill), .fill_vpn(va_q[AW-1:PAGE_BITS]), .fill_data(tlb_wr),
    .inv_all(flush_all), .inv_page(flush_page), .inv_vpn(flush_vpn)
  );

  // named events for the checks
  logic evt_accept, evt_in_window, evt_bypass, evt_pte_bad, flush_any;
  logic [AW-1:0] win_base;
  assign evt_accept    = req_valid && req_ready;
  assign win_base      = window_base(size_code);
  assign evt_in_window = (va_q >= win_base);
  assign evt_bypass    = slot_bypass[slot_q];
  assign evt_pte_bad   = !mem_rsp_data[PTE_VALID] || (wr_q && !mem_rsp_data[PTE_WRITE]);
  assign flush_any     = flush_all || flush_page;

  logic unused_pte;
  assign unused_pte = ^{mem_rsp_data[31:27], mem_rsp_data[7:3], mem_rsp_data[0]};

  always_comb begin
    state_d  = state_q;
    paddr_d  = paddr_q;
    maddr_d  = maddr_q;
    tlb_fill = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_CHECK;
      ST_CHECK: begin
        if (evt_bypass) begin
          paddr_d = bypass_addr(va_q, slot_a30[slot_q]);
          state_d = ST_RESP;
        end else if (!xl_enable) begin
          paddr_d = va_q;
          state_d = ST_RESP;
        end else if (!evt_in_window) begin
          state_d = ST_FAULT;
        end else if (tlb_hit) begin
          if (wr_q && !tlb_rd.writable) state_d = ST_FAULT;
          else begin
            paddr_d = phys_addr(tlb_rd.ppn, va_q);
            state_d = ST_RESP;
          end
        end else begin
          maddr_d = entry_addr(pt_base, va_q, win_base);
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (evt_pte_bad) state_d = ST_FAULT;
          else begin
            paddr_d  = phys_addr(tlb_wr.ppn, va_q);
            tlb_fill = !stale_q && !flush_any;
            state_d  = ST_RESP;
          end
        end
      end
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      slot_q  <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      stale_q <= 1'b0;
    end else begin
      state_q <= state_d;
      paddr_q <= paddr_d;
      maddr_q <= maddr_d;
      if (evt_accept) begin
        va_q   <= req_vaddr;
        wr_q   <= req_write;
        slot_q <= req_slot;
      end
      // a flush while the entry read is in flight makes that entry stale
      if (state_q == ST_CHECK) stale_q <= 1'b0;
      else if (flush_any)      stale_q <= 1'b1;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign fault_valid   = (state_q == ST_FAULT);
  assign fault_vaddr   = va_q;
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = maddr_q;

  a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)));

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r12_rsp_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fault_valid));
endmodule

// File: tb/dvx_xlate_test.sv
module dvx_xlate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0]  req_slot = 0;
  logic [31:0] req_vaddr = 0;
  logic        mem_req_ready = 1, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        req_ready, rsp_valid, fault_valid, mem_req_valid;
  logic [31:0] rsp_paddr, fault_vaddr, mem_req_addr;

  dvx_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0;
  int n_errors = 0;

  // behavioural model state
  logic [31:0] pt_mem [logic [31:0]];
  bit          m_en = 0;
  int          m_code = 0;
  logic [31:0] m_base = 0;
  logic [31:0] m_cfg [4] = '{default: 0};
  bit          m_v [16] = '{default: 0};
  logic [19:0] m_tag [16];
  logic [31:0] m_pte [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input int ppn, input bit valid, input bit wr);
    return (32'(ppn) << 8) | (32'(wr) << 2) | (32'(valid) << 1);
  endfunction

  task automatic wr_reg(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: begin m_en = d[0]; m_code = int'(d[4:2]); end
      1: m_base = d;
      2: for (int k = 0; k < 16; k++) m_v[k] = 0;
      3: if (m_v[d[15:12]] && m_tag[d[15:12]] == d[31:12]) m_v[d[15:12]] = 0;
      default: m_cfg[sel-4] = d;
    endcase
  endtask

  task automatic model_access(input int slot, input logic [31:0] va, input bit wr,
                              input bit stale, output bit f, output logic [31:0] pa,
                              output int nf, output logic [31:0] ma);
    longint unsigned wb;
    int ix;
    bit hit;
    logic [31:0] e;
    f = 0; pa = 0; nf = 0; ma = 0;
    if (m_cfg[slot][0]) begin
      pa = va; pa[30] = m_cfg[slot][16];
      return;
    end
    if (!m_en) begin pa = va; return; end
    wb = 64'h1_0000_0000 - (64'h1 << (24 + m_code));
    if (longint'(va) < wb) begin f = 1; return; end
    ix = int'(va[15:12]);
    hit = m_v[ix] && (m_tag[ix] == va[31:12]);
    if (hit) e = m_pte[ix];
    else begin
      nf = 1;
      ma = m_base + 32'(((longint'(va) - wb) / 4096) * 4);
      e = pt_mem.exists(ma) ? pt_mem[ma] : 32'h0;
    end
    if (stale) for (int k = 0; k < 16; k++) m_v[k] = 0;
    if (!e[1] || (wr && !e[2])) begin f = 1; return; end
    if (!hit && !stale) begin m_v[ix] = 1; m_tag[ix] = va[31:12]; m_pte[ix] = e; end
    pa = {1'b0, e[26:8], va[11:0]};
  endtask

  task automatic run_req(input int slot, input logic [31:0] va, input bit wr,
                         input bit flush_mid, input int hold, input string rq);
    bit e_f, done, accepted, got_f, pend, busy_ok, stable_ok;
    logic [31:0] e_pa, e_ma, got_pa, got_ma, got_fa, pend_addr;
    int e_nf, fetches, held;
    done = 0; accepted = 0; got_f = 0; pend = 0; busy_ok = 1; stable_ok = 1;
    got_pa = 0; got_ma = 0; got_fa = 0; pend_addr = 0; fetches = 0; held = 0;
    model_access(slot, va, wr, flush_mid, e_f, e_pa, e_nf, e_ma);
    @(negedge clk);
    req_valid = 1; req_slot = 2'(slot); req_vaddr = va; req_write = wr;
    rsp_ready = (hold == 0);
    for (int c = 0; c < 60 && !done; c++) begin
      cfg_we = 0;
      if (accepted) req_valid = 0;
      if (accepted && req_ready) busy_ok = 0;
      if (!accepted && req_valid && req_ready) accepted = 1;
      mem_rsp_valid = pend;
      mem_rsp_data  = (pend && pt_mem.exists(pend_addr)) ? pt_mem[pend_addr] : 32'h0;
      pend = 0;
      if (mem_req_valid) begin
        fetches++; got_ma = mem_req_addr; pend = 1; pend_addr = mem_req_addr;
        if (flush_mid) begin cfg_we = 1; cfg_sel = 3'd2; cfg_wdata = 32'h0; end
      end
      if (rsp_valid) begin
        if (held > 0 && rsp_paddr != got_pa) stable_ok = 0;
        got_pa = rsp_paddr;
        held++;
        if (held > hold) begin rsp_ready = 1; done = 1; end
      end
      if (fault_valid) begin got_f = 1; got_fa = fault_vaddr; done = 1; end
      @(negedge clk);
    end
    cfg_we = 0; req_valid = 0; rsp_ready = 1; mem_rsp_valid = 0;
    if (fault_valid || rsp_valid) busy_ok = 0;
    chk(done, rq, "request completes", 32'(done), 1);
    chk(got_f == e_f, rq, "fault flag", 32'(got_f), 32'(e_f));
    if (e_f) chk(got_fa == va, rq, "fault address", got_fa, va);
    else     chk(got_pa == e_pa, rq, "physical address", got_pa, e_pa);
    chk(fetches == e_nf, rq, "entry reads", 32'(fetches), 32'(e_nf));
    if (e_nf > 0) chk(got_ma == e_ma, rq, "entry address", got_ma, e_ma);
    chk(busy_ok, "R12", "single outstanding / pulse", 32'(busy_ok), 1);
    if (hold > 0) chk(stable_ok && held == hold + 1, "R12", "response held under backpressure",
                      32'(held), 32'(hold + 1));
  endtask

  initial begin
    #(20 * 100000);
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1, "R1", "req_ready in reset", 32'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && !rsp_valid && !fault_valid && !mem_req_valid, "R1", "idle outputs",
        {req_ready, rsp_valid, fault_valid, mem_req_valid}, 4'b1000);

    // page table at 0x0010_0000 for code 0 (window 0xFF000000..)
    for (int i = 0; i < 40; i++) pt_mem[32'h0010_0000 + 32'(4 * i)] = pte(32'h10000 + i, 1, 1);
    pt_mem[32'h0010_0000 + 4 * 8]  = pte(32'h20008, 0, 1); // invalid page 8
    pt_mem[32'h0010_0000 + 4 * 9]  = pte(32'h20009, 1, 0); // read-only page 9
    pt_mem[32'h0010_0000 + 4 * 10] = pte(32'h2000A, 1, 0); // read-only page 10

    // R3: disabled passes address through
    run_req(0, 32'h1234_5678, 0, 0, 0, "R3");
    run_req(0, 32'hFF00_3ABC, 1, 0, 0, "R3");

    // R2 R5 R6: enable code 0 with base
    wr_reg(1, 32'h0010_0000);
    wr_reg(0, 32'h0000_0001);
    run_req(0, 32'hFF00_3ABC, 0, 0, 0, "R5");
    run_req(0, 32'hFF00_3123, 1, 0, 0, "R8");   // hit
    run_req(1, 32'hFF00_0000, 0, 0, 0, "R6");   // first byte of window
    // R4: just below window and far below
    run_req(0, 32'hFEFF_FFFF, 0, 0, 0, "R4");
    run_req(0, 32'h0000_1000, 1, 0, 0, "R4");

    // R7: invalid entry faults and is not cached
    run_req(0, 32'hFF00_8010, 0, 0, 0, "R7");
    run_req(0, 32'hFF00_8010, 0, 0, 0, "R7");
    // read-only: write on fresh read faults, not cached, read refetches
    run_req(0, 32'hFF00_9000, 1, 0, 0, "R7");
    run_req(0, 32'hFF00_9004, 0, 0, 0, "R7");
    // cached read-only page: write hits and faults
    run_req(0, 32'hFF00_A000, 0, 0, 0, "R7");
    run_req(0, 32'hFF00_A008, 1, 0, 0, "R7");

    // R8: index conflict evicts
    run_req(0, 32'hFF01_3000, 0, 0, 0, "R8");
    run_req(0, 32'hFF00_3000, 0, 0, 0, "R8");

    // R10: page flush with low bits set, neighbour survives
    run_req(0, 32'hFF00_4000, 0, 0, 0, "R10");
    run_req(0, 32'hFF00_5000, 0, 0, 0, "R10");
    run_req(0, 32'hFF00_6000, 0, 0, 0, "R10");
    wr_reg(3, 32'hFF00_4FFF);
    run_req(0, 32'hFF00_4000, 0, 0, 0, "R10");
    run_req(0, 32'hFF00_5000, 0, 0, 0, "R10");
    wr_reg(3, 32'hFF01_6000);                    // same index as 0xFF006, other tag
    run_req(0, 32'hFF00_6000, 0, 0, 0, "R10");

    // R9: flush-all with arbitrary data
    wr_reg(2, 32'hDEAD_BEEF);
    run_req(0, 32'hFF00_5000, 0, 0, 0, "R9");
    run_req(0, 32'hFF00_3000, 0, 0, 0, "R9");

    // R13: flush during entry read
    run_req(0, 32'hFF00_7000, 0, 1, 0, "R13");
    run_req(0, 32'hFF00_7000, 0, 0, 0, "R13");

    // R11: bypass slots
    wr_reg(6, 32'h0001_0001);
    wr_reg(7, 32'h0000_0001);
    run_req(2, 32'h0000_0123, 0, 0, 0, "R11");
    run_req(3, 32'hC000_0123, 1, 0, 0, "R11");
    run_req(0, 32'h0000_0123, 0, 0, 0, "R11");   // slot 0 still faults

    // R2 R4: largest window, new base
    wr_reg(1, 32'h0020_0000);
    wr_reg(0, 32'h0000_001D);
    pt_mem[32'h0020_0000 + 4 * 5] = pte(32'h3ABCD, 1, 1);
    run_req(1, 32'h8000_5FFF, 0, 0, 0, "R2");
    run_req(1, 32'h7FFF_FFFF, 0, 0, 0, "R4");
    run_req(1, 32'h8000_0000, 0, 0, 0, "R4");

    // R12: response backpressure
    run_req(1, 32'h8000_5010, 0, 0, 3, "R12");
    run_req(1, 32'h8000_5020, 1, 0, 1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule